// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the bus-facing front end of a 128-byte memory that hangs on an open-drain two-wire bus. It oversamples the bus clock and data lines with a fast system clock, passes each through a two-stage synchronizer, and derives clock edges and the two bus conditions from the synchronized copies. A data-line fall while the bus clock is high opens a transfer. A data-line rise while the bus clock is high closes it. Data-line changes while the bus clock is low are data.

The first byte of every transfer is a command. It carries a 7-bit word address and then a direction bit. The block acknowledges that byte unless the write controller reports that it is busy.

In write direction, every following byte is stored at the current address and acknowledged, and the address then advances. In read direction, the block shifts out the byte at the current address, MSB first. It continues with the next address for as long as the master acknowledges. The address wraps over the whole 128-byte space. The data line is never driven high: the block only asserts an active-high pull-low enable and reads the wired line back. The storage is a plain 128x8 register file with a synchronous write.

Top module: `twoWireMemSlave`

## Requirements
- R1: After reset the pull-low enable `sdaOe` is 0 and every one of the 128 bytes reads back as 0x00.
- R2: Until the first start condition, bus clocks and data are ignored: no byte is acknowledged and `sdaOe` never asserts.
- R3: The first byte after a start is taken as address bits 6..0 (MSB first) followed by a direction bit (1 = read, 0 = write). With `busy` low, the block pulls SDA low for the whole ninth bus clock that follows it.
- R4: If `busy` is high when the command byte completes, the block leaves SDA released on the ninth clock. It then ignores all further bytes until the next start.
- R5: In write direction, each data byte (MSB first) is stored at the current address and acknowledged on its ninth clock. The address then increments by one, wrapping from 127 to 0.
- R6: In read direction, the byte at the current address is presented MSB first, one bit per bus clock, each bit changing only after a bus clock fall. After a master acknowledge (SDA low on the ninth clock), the next byte comes from address + 1, wrapping from 127 to 0.
- R7: After a master no-acknowledge (SDA high on the ninth clock), the block keeps SDA released until a stop or a start, even if further clocks arrive.
- R8: A stop (SDA rising while SCL is high) returns the block to idle at any point, including partway through a read byte. Clocks that follow it without a start are ignored.
- R9: A start seen in the middle of any transfer abandons the current byte and begins reception of a fresh command byte.
- R10: `sdaOe` only rises while the bus clock is low. Every drive change follows a synchronized bus clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Wired bus data line read back |
| busy | input | 1 | Write controller busy; suppresses the command acknowledge |
| sdaOe | output | 1 | Active-high enable that pulls the data line low |

## Verification
The main function is exercised with a table of command/data pairs written one byte per transfer and read back one byte per transfer. This shows that address decoding and data storage are right for scattered addresses. Multi-byte writes and sequential reads that start at address 127 separate correct wrap-around from a counter that saturates or skips. A sequential read into a byte never written, followed by a master no-acknowledge with a zero bit pending, tells a block that stops transmitting from one that keeps driving. Busy-blocked commands, a repeated start inside a command byte, and a stop issued one bit into a read byte each show whether bus conditions override the byte framing.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_WAIT_STOP
  } twsState_e;

  // events and values the datapath reports to the control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
    logic cntFull;
    logic rwBit;
    logic txNext;
    logic memMsb;
  } busEv_t;

  // strobes the control issues to the datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftIn;
    logic loadAddr;
    logic incAddr;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
  } ctlStrobe_t;

endpackage

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  ctlStrobe_t strobe,
  output busEv_t     ev
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_LEN-1:0] sclSync, sdaSync;
  logic                sclPrev, sdaPrev;
  logic                sclNow, sdaNow;
  logic [CNT_W-1:0]    bitCnt;
  logic [DATA_W-1:0]   rxReg, txReg;
  logic [ADDR_W-1:0]   addrReg;
  logic [DATA_W-1:0]   memArr [DEPTH];

  assign sclNow = sclSync[SYNC_LEN-1];
  assign sdaNow = sdaSync[SYNC_LEN-1];

  // bus line synchronizers, idle-high reset so no false edge appears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_LEN-2:0], scl};
      sdaSync <= {sdaSync[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxReg   <= '0;
      txReg   <= '0;
      addrReg <= '0;
    end else begin
      if (strobe.clrCnt)      bitCnt <= '0;
      else if (strobe.incCnt) bitCnt <= bitCnt + CNT_W'(1);
      if (strobe.shiftIn)  rxReg <= {rxReg[DATA_W-2:0], sdaNow};
      if (strobe.loadAddr) addrReg <= rxReg[DATA_W-1 -: ADDR_W];
      else if (strobe.incAddr) addrReg <= addrReg + ADDR_W'(1);
      if (strobe.loadTx)       txReg <= memArr[addrReg];
      else if (strobe.shiftTx) txReg <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

  // storage: synchronous write, direct read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (strobe.writeMem) begin
      memArr[addrReg] <= rxReg;
    end
  end

  always_comb begin
    ev.sclRise = sclNow & ~sclPrev;
    ev.sclFall = ~sclNow & sclPrev;
    ev.start   = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stop    = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaBit  = sdaNow;
    ev.cntFull = (bitCnt == CNT_W'(DATA_W));
    ev.rwBit   = rxReg[0];
    ev.txNext  = txReg[DATA_W-2];
    ev.memMsb  = memArr[addrReg][DATA_W-1];
  end

endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  busEv_t     ev,
  output ctlStrobe_t strobe,
  output twsState_e  state,
  output logic       sdaOe
);

  twsState_e stNext;
  logic      oeQ, oeNext;
  logic      rdMode, rdNext;
  logic      masterAck, ackNext;

  assign sdaOe = oeQ;

  always_comb begin
    stNext  = state;
    oeNext  = oeQ;
    rdNext  = rdMode;
    ackNext = masterAck;
    strobe  = '0;
    if (ev.stop) begin
      stNext = ST_IDLE;
      oeNext = 1'b0;
    end else if (ev.start) begin
      stNext        = ST_ADDR;
      oeNext        = 1'b0;
      strobe.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            strobe.shiftIn = 1'b1;
            strobe.incCnt  = 1'b1;
          end else if (ev.sclFall && ev.cntFull) begin
            strobe.loadAddr = 1'b1;
            rdNext          = ev.rwBit;
            oeNext          = ~busy;
            stNext          = ST_ADDR_ACK;
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            strobe.clrCnt = 1'b1;
            if (!oeQ) begin
              stNext = ST_IDLE;
            end else if (rdMode) begin
              strobe.loadTx = 1'b1;
              oeNext        = ~ev.memMsb;
              stNext        = ST_RD_DATA;
            end else begin
              oeNext = 1'b0;
              stNext = ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: begin
          if (ev.sclRise) begin
            strobe.shiftIn = 1'b1;
            strobe.incCnt  = 1'b1;
          end else if (ev.sclFall && ev.cntFull) begin
            strobe.writeMem = 1'b1;
            strobe.incAddr  = 1'b1;
            oeNext          = 1'b1;
            stNext          = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (ev.sclFall) begin
            strobe.clrCnt = 1'b1;
            oeNext        = 1'b0;
            stNext        = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (ev.sclRise) begin
            strobe.incCnt = 1'b1;
          end else if (ev.sclFall) begin
            if (ev.cntFull) begin
              strobe.incAddr = 1'b1;
              oeNext         = 1'b0;
              stNext         = ST_RD_ACK;
            end else begin
              strobe.shiftTx = 1'b1;
              oeNext         = ~ev.txNext;
            end
          end
        end
        ST_RD_ACK: begin
          if (ev.sclRise) begin
            ackNext = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              strobe.clrCnt = 1'b1;
              oeNext        = ~ev.memMsb;
              stNext        = ST_RD_DATA;
            end else begin
              oeNext = 1'b0;
              stNext = ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      oeQ       <= 1'b0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stNext;
      oeQ       <= oeNext;
      rdMode    <= rdNext;
      masterAck <= ackNext;
    end
  end

endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import twsPkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  input  logic busy,
  output logic sdaOe
);

  busEv_t     busEv;
  ctlStrobe_t strobes;
  twsState_e  ctlState;

  twsDatapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SYNC_LEN(SYNC_LEN)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .scl   (scl),
    .sdaIn (sdaIn),
    .strobe(strobes),
    .ev    (busEv)
  );

  twsControl ctl (
    .clk   (clk),
    .rstN  (rstN),
    .busy  (busy),
    .ev    (busEv),
    .strobe(strobes),
    .state (ctlState),
    .sdaOe (sdaOe)
  );

endmodule

// File: rtl/twoWireMemSlave_chk.sv
module twoWireMemSlave_chk
  import twsPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      scl,
  input logic      busy,
  input logic      sdaOe,
  input twsState_e state,
  input logic      startEv,
  input logic      stopEv
);

  // R1: reset leaves the line released
  a_r1_reset_release: assert property (@(posedge clk) !rstN |=> !sdaOe);

  // R2: no drive while idle
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R4: command completed while busy gives no acknowledge
  a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == ST_ADDR_ACK) && $past(busy)) |-> !sdaOe);

  // R7: after a no-acknowledge the line stays released
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_STOP) |-> !sdaOe);

  // R8: stop returns to idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE));

  // R9: start begins a fresh command byte
  a_r9_start_restart: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (state == ST_ADDR && !sdaOe));

  // R10: drive only begins while the bus clock is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !scl);

endmodule

bind twoWireMemSlave twoWireMemSlave_chk chk (
  .clk    (clk),
  .rstN   (rstN),
  .scl    (scl),
  .busy   (busy),
  .sdaOe  (sdaOe),
  .state  (ctlState),
  .startEv(busEv.start),
  .stopEv (busEv.stop)
);

// File: tb/twoWireMemSlave_test.sv
`timescale 1ns/1ps
module twoWireMemSlave_test;

  localparam int HALF = 16;
  localparam int NVEC = 4;
  // each entry: {address[6:0], data[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {7'h05, 8'hA5}, {7'h06, 8'h3C}, {7'h40, 8'h81}, {7'h41, 8'hC2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic busy = 1'b0;
  logic sdaOe;
  logic sdaBus;
  int checks = 0;
  int errors = 0;
  int oeHits = 0;
  logic [7:0] model [128];

  assign sdaBus = mSda & ~sdaOe;

  always #2.5 clk = ~clk;

  twoWireMemSlave uut (
    .clk  (clk),
    .rstN (rstN),
    .scl  (scl),
    .sdaIn(sdaBus),
    .busy (busy),
    .sdaOe(sdaOe)
  );

  always @(negedge clk) if (sdaOe) oeHits++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(output logic s);
    waitClk(HALF);
    scl = 1'b1;
    waitClk(HALF / 2);
    s = sdaBus;
    waitClk(HALF / 2);
    scl = 1'b0;
    waitClk(4);
  endtask

  task automatic busStart();
    mSda = 1'b1;
    waitClk(HALF);
    scl = 1'b1;
    waitClk(HALF);
    mSda = 1'b0;
    waitClk(HALF);
    scl = 1'b0;
    waitClk(4);
  endtask

  task automatic busStop();
    mSda = 1'b0;
    waitClk(HALF);
    scl = 1'b1;
    waitClk(HALF);
    mSda = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i];
      clockBit(s);
    end
    mSda = 1'b1;
    clockBit(s);
    ack = ~s;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    logic s;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(s);
      b[i] = s;
    end
    mSda = ~mAck;
    clockBit(s);
    mSda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;

    waitClk(5);
    check(sdaOe == 1'b0, "R1 released in reset", sdaOe, 0);
    rstN = 1'b1;
    waitClk(5);
    check(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);

    // R2: a whole byte clocked with no start is ignored
    scl = 1'b0;
    waitClk(4);
    oeHits = 0;
    sendByte({7'h10, 1'b1}, ack);
    check(ack == 1'b0, "R2 no ack before start", ack, 0);
    check(oeHits == 0, "R2 no drive before start", oeHits, 0);
    busStop();

    // R1: unwritten byte reads as zero
    busStart();
    sendByte({7'h10, 1'b1}, ack);
    check(ack == 1'b1, "R3 read command ack", ack, 1);
    readByte(1'b0, rd);
    check(rd == 8'h00, "R1 reset contents", rd, 0);
    busStop();

    // table: one write per transfer
    for (int v = 0; v < NVEC; v++) begin
      busStart();
      sendByte({VEC[v][14:8], 1'b0}, ack);
      check(ack == 1'b1, "R3 write command ack", ack, 1);
      sendByte(VEC[v][7:0], ack);
      check(ack == 1'b1, "R5 data byte ack", ack, 1);
      model[VEC[v][14:8]] = VEC[v][7:0];
      busStop();
    end
    // table: one read per transfer
    for (int v = 0; v < NVEC; v++) begin
      busStart();
      sendByte({VEC[v][14:8], 1'b1}, ack);
      readByte(1'b0, rd);
      check(rd == model[VEC[v][14:8]], "R6 table readback", rd, model[VEC[v][14:8]]);
      busStop();
    end

    // R5: multi-byte write wraps 127 -> 0
    busStart();
    sendByte({7'h7F, 1'b0}, ack);
    sendByte(8'h9B, ack);
    check(ack == 1'b1, "R5 first burst byte ack", ack, 1);
    sendByte(8'h47, ack);
    check(ack == 1'b1, "R5 wrapped byte ack", ack, 1);
    model[127] = 8'h9B;
    model[0] = 8'h47;
    busStop();

    // R6: sequential read wraps 127 -> 0
    busStart();
    sendByte({7'h7F, 1'b1}, ack);
    readByte(1'b1, rd);
    check(rd == model[127], "R6 byte at 127", rd, model[127]);
    readByte(1'b0, rd);
    check(rd == model[0], "R5 R6 wrapped byte at 0", rd, model[0]);
    busStop();

    // R6: sequential read through written and unwritten bytes
    busStart();
    sendByte({7'h05, 1'b1}, ack);
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, rd);
      check(rd == model[5 + k], "R6 sequential byte", rd, model[5 + k]);
    end
    busStop();

    // R7: after a no-acknowledge nothing is driven, even with a zero byte next
    busStart();
    sendByte({7'h06, 1'b1}, ack);
    readByte(1'b0, rd);
    check(rd == 8'h3C, "R7 byte before nack", rd, 8'h3C);
    oeHits = 0;
    for (int k = 0; k < 9; k++) begin
      logic s;
      clockBit(s);
    end
    check(oeHits == 0, "R7 released after nack", oeHits, 0);
    busStop();

    // R4: busy blocks the command ack and the following byte
    busy = 1'b1;
    busStart();
    sendByte({7'h20, 1'b0}, ack);
    check(ack == 1'b0, "R4 no ack while busy", ack, 0);
    busy = 1'b0;
    sendByte(8'h55, ack);
    check(ack == 1'b0, "R4 data ignored after busy nack", ack, 0);
    busStop();
    busStart();
    sendByte({7'h20, 1'b1}, ack);
    readByte(1'b0, rd);
    check(rd == 8'h00, "R4 nothing stored while busy", rd, 0);
    busStop();

    // R9: repeated start in the middle of a command byte
    busStart();
    mSda = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic s;
      clockBit(s);
    end
    busStart();
    sendByte({7'h40, 1'b1}, ack);
    check(ack == 1'b1, "R9 ack after repeated start", ack, 1);
    readByte(1'b0, rd);
    check(rd == 8'h81, "R9 data after repeated start", rd, 8'h81);
    busStop();

    // R8: stop one bit into a read byte (next byte MSB is 1, line free)
    busStart();
    sendByte({7'h40, 1'b1}, ack);
    readByte(1'b1, rd);
    check(rd == 8'h81, "R8 byte before stop", rd, 8'h81);
    busStop();
    waitClk(8);
    check(sdaOe == 1'b0, "R8 released at stop", sdaOe, 0);
    scl = 1'b0;
    waitClk(4);
    oeHits = 0;
    sendByte({7'h41, 1'b1}, ack);
    check(ack == 1'b0 && oeHits == 0, "R8 idle after stop", oeHits, 0);
    busStop();

    // R10: drive polarity on a fresh read with mixed bits
    busStart();
    sendByte({7'h41, 1'b1}, ack);
    readByte(1'b0, rd);
    check(rd == 8'hC2, "R10 R6 bit order", rd, 8'hC2);
    busStop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule